// File: doc/BRIEF.md
# Indirect Addressing Data Memory Port

This unit sits between an 8-bit core and its data memory. The core presents one direct byte address per cycle. The unit returns the byte found there and, when the write strobe is high, stores the core's byte there. Two pointer registers, each 7 bits wide, live at fixed addresses. Each pointer is paired with a virtual location that has no storage of its own. Any access to a virtual location is redirected to the byte whose address the paired pointer holds.

General-purpose RAM is modelled inside the unit as a 128-byte register array. The RAM is indexed by the low 7 bits of the resolved address. The accumulator and the other special-function registers are served by logic outside this unit. Their addresses in the low window read back zero here, and writes to them are dropped here. Moving a byte from one memory location to another therefore takes a read into the accumulator followed by a write.

Top module: `idm_port`

## Requirements
- R1: After reset both pointers hold 0 and every RAM byte holds 0x00. Reading address 0x01 or 0x03 then returns 0x80.
- R2: A write to address 0x01 loads pointer 0, and a write to address 0x03 loads pointer 1. Only bits 6..0 of the write data are stored.
- R3: Reading address 0x01 or 0x03 returns the pointer value in bits 6..0, with bit 7 forced to 1.
- R4: Reads and writes at address 0x00 reach the byte selected by pointer 0. Reads and writes at address 0x02 reach the byte selected by pointer 1. A pointer value of 0x40 or above selects RAM entry (pointer value).
- R5: Suppose an access at 0x00 or 0x02 resolves through its pointer to 0x00 or 0x02. A read then returns 0x00, and a write changes no RAM byte and no pointer.
- R6: Direct addresses 0x40 to 0xFF select RAM entry (address mod 128). For example, 0xC5 and 0x45 name the same byte, and 0x85 names entry 0x05.
- R7: An indirect access whose pointer holds 0x01 or 0x03 reads or writes that pointer register, with the same 7-bit rules as a direct access.
- R8: Addresses 0x04 to 0x3F, including the accumulator slot 0x05, read 0x00 whether reached directly or through a pointer. Writes to them change nothing in this unit.
- R9: Read data follows the address combinationally within the same cycle. Writes take effect only on a rising clock edge with the write strobe high. With the strobe low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the pointers and the RAM |
| addr | input | 8 | Direct data-memory address from the core |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Byte at the current address, after redirection |

## Verification
The bench builds the unit with its default parameters: an 8-bit address and data path, 7-bit pointers, a 128-entry RAM, and the RAM window starting at 0x40. With these values every decode class can be reached from the ports. These are pointer-to-RAM and pointer-to-pointer redirection, pointer-to-virtual-location nulling, the dead low window including 0x05, and the aliasing of 0x80..0xFF onto the array. The width mismatch between the 8-bit data bus and the 7-bit pointers is exercised by writing bytes with bit 7 set and reading them back.

// File: rtl/idm_pkg.sv
package idm_pkg;

  // Where a resolved access lands.
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,  // low window with nothing here: read 0, write dropped
    TGT_PTR0 = 3'd1,  // pointer register 0
    TGT_PTR1 = 3'd2,  // pointer register 1
    TGT_RAM  = 3'd3,  // general-purpose byte array
    TGT_NULL = 3'd4   // indirect access landing on a virtual location
  } tgt_e;

endpackage

// File: rtl/idm_ptr_reg.sv
module idm_ptr_reg #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [PTR_W-1:0]  q,
  output logic [DATA_W-1:0] rd_view
);

  localparam int PAD_W = DATA_W - PTR_W;

  // Read view: unimplemented upper bits read back as ones.
  function automatic logic [DATA_W-1:0] widen(logic [PTR_W-1:0] v);
    return {{PAD_W{1'b1}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wd[PTR_W-1:0];
  end

  assign rd_view = widen(q);

endmodule

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                PTR_W    = 7,
  parameter logic [ADDR_W-1:0] IND0_AT  = 8'h00,
  parameter logic [ADDR_W-1:0] PTR0_AT  = 8'h01,
  parameter logic [ADDR_W-1:0] IND1_AT  = 8'h02,
  parameter logic [ADDR_W-1:0] PTR1_AT  = 8'h03,
  parameter logic [ADDR_W-1:0] GPR_BASE = 8'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTR_W-1:0]  mp0,
  input  logic [PTR_W-1:0]  mp1,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              via_ind,
  output tgt_e              tgt
);

  localparam int EXT_W = ADDR_W - PTR_W;

  function automatic logic [ADDR_W-1:0] extend(logic [PTR_W-1:0] p);
    return {{EXT_W{1'b0}}, p};
  endfunction

  function automatic tgt_e classify(logic [ADDR_W-1:0] a, logic ind);
    if (ind && (a == IND0_AT || a == IND1_AT)) return TGT_NULL;
    if (a == PTR0_AT)                          return TGT_PTR0;
    if (a == PTR1_AT)                          return TGT_PTR1;
    if (a >= GPR_BASE)                         return TGT_RAM;
    return TGT_NONE;
  endfunction

  always_comb begin
    via_ind  = 1'b0;
    eff_addr = addr;
    if (addr == IND0_AT) begin
      via_ind  = 1'b1;
      eff_addr = extend(mp0);
    end else if (addr == IND1_AT) begin
      via_ind  = 1'b1;
      eff_addr = extend(mp1);
    end
  end

  assign tgt = classify(eff_addr, via_ind);

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wd;
    end
  end

  assign rd = mem[idx];

endmodule

// File: rtl/idm_port.sv
module idm_port
  import idm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PTR_W    = 7,
  parameter int RAM_AW   = 7,
  parameter int GPR_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NPTR = 2;
  localparam logic [ADDR_W-1:0] GPR_AT = ADDR_W'(GPR_BASE);

  // Named internal events, visible to the bound checker.
  logic [PTR_W-1:0]  mp     [NPTR];
  logic [DATA_W-1:0] mp_rd  [NPTR];
  logic [NPTR-1:0]   ptr_we;
  logic              ram_we;
  logic [ADDR_W-1:0] eff_addr;
  logic              via_ind;
  tgt_e              tgt;
  logic [DATA_W-1:0] ram_rd;
  logic [PTR_W-1:0]  mp0, mp1;

  assign mp0 = mp[0];
  assign mp1 = mp[1];

  idm_decode #(
    .ADDR_W  (ADDR_W),
    .PTR_W   (PTR_W),
    .GPR_BASE(GPR_AT)
  ) u_dec (
    .addr    (addr),
    .mp0     (mp0),
    .mp1     (mp1),
    .eff_addr(eff_addr),
    .via_ind (via_ind),
    .tgt     (tgt)
  );

  assign ptr_we[0] = wr_en && (tgt == TGT_PTR0);
  assign ptr_we[1] = wr_en && (tgt == TGT_PTR1);
  assign ram_we    = wr_en && (tgt == TGT_RAM);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    idm_ptr_reg #(
      .DATA_W(DATA_W),
      .PTR_W (PTR_W)
    ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ptr_we[g]),
      .wd     (wr_data),
      .q      (mp[g]),
      .rd_view(mp_rd[g])
    );
  end

  idm_ram #(
    .DATA_W(DATA_W),
    .RAM_AW(RAM_AW)
  ) u_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (ram_we),
    .idx  (eff_addr[RAM_AW-1:0]),
    .wd   (wr_data),
    .rd   (ram_rd)
  );

  always_comb begin
    unique case (tgt)
      TGT_PTR0: rd_data = mp_rd[0];
      TGT_PTR1: rd_data = mp_rd[1];
      TGT_RAM:  rd_data = ram_rd;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/idm_port_chk.sv
module idm_port_chk
  import idm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input tgt_e              tgt,
  input logic              ram_we,
  input logic [1:0]        ptr_we,
  input logic [PTR_W-1:0]  mp0,
  input logic [PTR_W-1:0]  mp1
);

  AST_NULL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == TGT_NULL |-> rd_data == '0);                                   // R5
  AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == TGT_NULL |-> !ram_we && ptr_we == 2'b00);                      // R5
  AST_PTR_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_PTR0 || tgt == TGT_PTR1) |-> rd_data[DATA_W-1]);          // R3
  AST_PTR0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we[0] |=> mp0 == $past(wr_data[PTR_W-1:0]));                      // R2
  AST_PTR1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we[1] |=> mp1 == $past(wr_data[PTR_W-1:0]));                      // R2
  AST_PTR0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we[0] |=> $stable(mp0));                                         // R9
  AST_PTR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we[1] |=> $stable(mp1));                                         // R9
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, ptr_we}));                                          // R9
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !ram_we && ptr_we == 2'b00);                               // R9
  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tgt == TGT_NONE |-> rd_data == '0 && !ram_we);                        // R8

endmodule

bind idm_port idm_port_chk #(
  .DATA_W(DATA_W),
  .PTR_W (PTR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .tgt    (tgt),
  .ram_we (ram_we),
  .ptr_we (ptr_we),
  .mp0    (mp0),
  .mp1    (mp1)
);

// File: tb/tb_idm_port.sv
module tb_idm_port;

  typedef struct packed {
    logic       wr;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h01, 8'h00, 8'h80, 4'd1},  // R1 pointer 0 reset view
    '{1'b0, 8'h03, 8'h00, 8'h80, 4'd1},  // R1 pointer 1 reset view
    '{1'b0, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 mp0=0 lands on itself
    '{1'b1, 8'h01, 8'hFF, 8'h00, 4'd2},  // R2
    '{1'b0, 8'h01, 8'h00, 8'hFF, 4'd3},  // R3
    '{1'b1, 8'h01, 8'h45, 8'h00, 4'd2},  // R2
    '{1'b0, 8'h01, 8'h00, 8'hC5, 4'd3},  // R3
    '{1'b1, 8'h00, 8'hA5, 8'h00, 4'd4},  // R4 write via mp0
    '{1'b0, 8'h45, 8'h00, 8'hA5, 4'd6},  // R6
    '{1'b0, 8'hC5, 8'h00, 8'hA5, 4'd6},  // R6 alias
    '{1'b1, 8'h03, 8'h70, 8'h00, 4'd2},  // R2
    '{1'b1, 8'h02, 8'h3C, 8'h00, 4'd4},  // R4 write via mp1
    '{1'b0, 8'h70, 8'h00, 8'h3C, 4'd6},  // R6
    '{1'b0, 8'h02, 8'h00, 8'h3C, 4'd4},  // R4 read via mp1
    '{1'b1, 8'h03, 8'h00, 8'h00, 4'd2},  // R2
    '{1'b0, 8'h02, 8'h00, 8'h00, 4'd5},  // R5
    '{1'b1, 8'h02, 8'h77, 8'h00, 4'd5},  // R5 dropped write
    '{1'b0, 8'h45, 8'h00, 8'hA5, 4'd5},  // R5 ram intact
    '{1'b0, 8'h70, 8'h00, 8'h3C, 4'd5},  // R5 ram intact
    '{1'b0, 8'h01, 8'h00, 8'hC5, 4'd5},  // R5 mp0 intact
    '{1'b0, 8'h03, 8'h00, 8'h80, 4'd5},  // R5 mp1 intact
    '{1'b1, 8'h01, 8'h02, 8'h00, 4'd2},  // R2
    '{1'b0, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 mp0 -> 0x02
    '{1'b1, 8'h00, 8'h55, 8'h00, 4'd5},  // R5 dropped write
    '{1'b0, 8'h03, 8'h00, 8'h80, 4'd5},  // R5 mp1 intact
    '{1'b0, 8'h01, 8'h00, 8'h82, 4'd5},  // R5 mp0 intact
    '{1'b1, 8'h01, 8'h03, 8'h00, 4'd7},  // R7 aim mp0 at mp1
    '{1'b1, 8'h00, 8'h92, 8'h00, 4'd7},  // R7 write mp1 indirectly
    '{1'b0, 8'h03, 8'h00, 8'h92, 4'd7},  // R7
    '{1'b0, 8'h00, 8'h00, 8'h92, 4'd7},  // R7 read through
    '{1'b1, 8'h05, 8'h99, 8'h00, 4'd8},  // R8
    '{1'b0, 8'h05, 8'h00, 8'h00, 4'd8},  // R8
    '{1'b0, 8'h3F, 8'h00, 8'h00, 4'd8},  // R8
    '{1'b1, 8'h85, 8'h11, 8'h00, 4'd6},  // R6 entry 0x05
    '{1'b0, 8'h85, 8'h00, 8'h11, 4'd6},  // R6
    '{1'b0, 8'h05, 8'h00, 8'h00, 4'd8},  // R8 entry 0x05 not at 0x05
    '{1'b1, 8'h01, 8'h40, 8'h00, 4'd2},  // R2
    '{1'b0, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 fresh byte
    '{1'b1, 8'h00, 8'h6B, 8'h00, 4'd4},  // R4
    '{1'b0, 8'h40, 8'h00, 8'h6B, 4'd6},  // R6
    '{1'b0, 8'hC0, 8'h00, 8'h6B, 4'd6}   // R6 alias
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  idm_port dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

  task automatic check(input logic [7:0] exp, input int req, input string what);
    n_run++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, rd_data, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = w; wr_data = d;
    #1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[i]) begin
      access(VEC[i].wr, VEC[i].a, VEC[i].d);
      if (!VEC[i].wr) check(VEC[i].e, int'(VEC[i].r), $sformatf("vector %0d", i));
    end

    // R9: strobe low across an edge leaves the byte alone
    access(1'b0, 8'h45, 8'hFF);
    access(1'b0, 8'h45, 8'h00);
    check(8'hA5, 9, "write with strobe low");

    // R9: read follows the address within one cycle
    @(negedge clk);
    addr = 8'h70; #1;
    check(8'h3C, 9, "combinational read a");
    addr = 8'h85; #1;
    check(8'h11, 9, "combinational read b");

    // R1: reset in the middle of a run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    access(1'b0, 8'h01, 8'h00);
    check(8'h80, 1, "mp0 after reset");
    access(1'b0, 8'h03, 8'h00);
    check(8'h80, 1, "mp1 after reset");
    access(1'b0, 8'h45, 8'h00);
    check(8'h00, 1, "ram after reset");

    finish_up();
  end

endmodule